// File: doc/BRIEF.md
# Telecom Spot-Frequency Reference Prescaler

This block prepares a reference clock for a digital PLL phase detector. The reference arrives as a plain signal that the block samples in the loop clock domain. A short synchronizer chain with a rising-edge detector turns that signal into one-cycle edge strobes. A divider then thins the strobes to the event rate the phase detector expects and emits one single-cycle event per divided period.

A 4-bit frequency code names which of twelve supported telecom spot frequencies is applied. A mode input picks one of two behaviours. In 8 kHz mode every input is brought down to an 8 kHz event rate. In direct mode each edge goes through at the input rate, except that the fastest spot (155.52 MHz) is always halved, because the phase detector accepts edges at 77.76 MHz at most. Inputs at 8 kHz or below are never divided. When the code or the mode changes, the divider restarts, so no shortened period appears in the middle of a cycle. A code outside the table silences the output.

Top module: `spot_prescaler`

## Requirements
- R1: After reset `evt_out` is low, and the divider count starts from zero.
- R2: With `div8k_mode`=1 the divide ratio follows the code: 0 = 2 kHz, 1 = 4 kHz and 2 = 8 kHz give 1; 3 (1.544 MHz) gives 193; 4 (2.048 MHz) gives 256; 5 (6.48 MHz) gives 810; 6 (19.44 MHz) gives 2430; 7 (25.92 MHz) gives 3240; 8 (38.88 MHz) gives 4860; 9 (51.84 MHz) gives 6480; 10 (77.76 MHz) gives 9720; 11 (155.52 MHz) gives 19440.
- R3: With `div8k_mode`=0 every detected input edge gives one event for codes 0 to 10, and code 11 gives one event for every second edge.
- R4: Codes 0, 1 and 2 give one event per input edge in both modes.
- R5: After reset or a restart, the first event comes on the ratio-th rising edge. After that there is exactly one event per ratio rising edges.
- R6: Any change of `freq_code` or `div8k_mode` clears the divider count. Edges counted before the change do not bring the next event forward.
- R7: Codes 12 to 15 produce no events in either mode.
- R8: Only rising edges of `ref_in` are counted: a level held high for many cycles counts as one edge. `evt_out` is never high for two cycles in a row.
- R9: With ratio 1, `evt_out` rises on the fourth rising `clk` edge after `ref_in` rises (two synchronizer stages, one edge register, one event register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop-domain clock that samples the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, sampled asynchronously |
| freq_code | input | 4 | Spot-frequency select code |
| div8k_mode | input | 1 | 1 = divide to 8 kHz, 0 = direct with halving of code 11 |
| evt_out | output | 1 | Single-cycle event per divided reference period |

## Verification
The divider is driven with edge counts one short of the ratio and exactly at the ratio, for ratios 193, 256, 810, 2430 and 9720. This separates an off-by-one ratio from a correct one, and a wrong table entry from a right one. In direct mode, a 2.048 MHz code against the 155.52 MHz code shows whether halving is applied only where it belongs. Low-rate codes are run in both modes to show they bypass division. A restart test switches codes partway through a period, and a long high level on the input confirms that only rising edges count. A single timed edge measures the pipeline latency and the width of the event pulse.

// File: rtl/spotpre_pkg.sv
package spotpre_pkg;

   localparam int SPOT_CODE_W = 4;
   localparam int NUM_SPOTS   = 12;
   localparam int MAX_RATIO   = 19440;
   localparam int HALVE_CODE  = 11;

   // divide ratio to 8 kHz; 0 marks an unsupported code
   function automatic int to8k_ratio(input int code);
      case (code)
         0, 1, 2: return 1;
         3:       return 193;
         4:       return 256;
         5:       return 810;
         6:       return 2430;
         7:       return 3240;
         8:       return 4860;
         9:       return 6480;
         10:      return 9720;
         11:      return 19440;
         default: return 0;
      endcase
   endfunction

   // ratio in direct mode: pass-through, fastest spot halved
   function automatic int direct_ratio(input int code);
      if (code == HALVE_CODE) return 2;
      if (code < NUM_SPOTS)   return 1;
      return 0;
   endfunction

endpackage

// File: rtl/spotpre_sync.sv
module spotpre_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("spotpre_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         rise_o <= 1'b0;
      end else begin
         last_q <= chain_q[STAGES-1];
         rise_o <= chain_q[STAGES-1] & ~last_q;
      end
   end
endmodule

// File: rtl/spotpre_ratio.sv
module spotpre_ratio
   import spotpre_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter int CNT_W  = 15
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              to8k_i,
   output logic [CNT_W-1:0]  ratio_o,
   output logic              valid_o
);
   int sel;

   if (CNT_W < $clog2(MAX_RATIO + 1)) begin : g_bad_width
      $error("spotpre_ratio: CNT_W too small for largest ratio");
   end
   if (CODE_W < SPOT_CODE_W) begin : g_bad_code
      $error("spotpre_ratio: CODE_W too small for spot table");
   end

   always_comb begin
      sel     = to8k_i ? to8k_ratio(int'(code_i)) : direct_ratio(int'(code_i));
      valid_o = (sel != 0);
      ratio_o = valid_o ? CNT_W'(sel) : CNT_W'(1);
   end
endmodule

// File: rtl/spotpre_div.sv
module spotpre_div #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   input  logic             valid_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] ratio_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             evt_o
);
   logic [CNT_W-1:0] last_idx;
   assign last_idx = ratio_i - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         evt_o <= 1'b0;
      end else begin
         evt_o <= 1'b0;
         if (restart_i) begin
            cnt_o <= '0;
         end else if (edge_i && valid_i) begin
            if (cnt_o >= last_idx) begin
               cnt_o <= '0;
               evt_o <= 1'b1;
            end else begin
               cnt_o <= cnt_o + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spot_prescaler.sv
module spot_prescaler #(
   parameter int CODE_W      = 4,
   parameter int CNT_W       = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic [CODE_W-1:0] freq_code,
   input  logic              div8k_mode,
   output logic              evt_out
);
   logic              rise_q;
   logic              cfg_valid;
   logic [CNT_W-1:0]  cfg_ratio;
   logic [CNT_W-1:0]  div_cnt;
   logic [CODE_W:0]   cfg_q;
   logic              cfg_change;

   assign cfg_change = (cfg_q != {freq_code, div8k_mode});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= {freq_code, div8k_mode};
   end

   spotpre_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ref_in), .rise_o(rise_q)
   );

   spotpre_ratio #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_ratio (
      .code_i(freq_code), .to8k_i(div8k_mode),
      .ratio_o(cfg_ratio), .valid_o(cfg_valid)
   );

   spotpre_div #(.CNT_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .edge_i(rise_q), .valid_i(cfg_valid),
      .restart_i(cfg_change), .ratio_i(cfg_ratio),
      .cnt_o(div_cnt), .evt_o(evt_out)
   );
endmodule

// File: rtl/spot_prescaler_chk.sv
module spot_prescaler_chk #(
   parameter int CODE_W = 4,
   parameter int CNT_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] freq_code,
   input logic              evt_out,
   input logic              rise_q,
   input logic              cfg_valid,
   input logic              cfg_change,
   input logic [CNT_W-1:0]  cfg_ratio,
   input logic [CNT_W-1:0]  div_cnt
);
   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out |=> !evt_out);

   // R7
   no_evt_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_code >= CODE_W'(12)) |=> !evt_out);

   // R6
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> (div_cnt == '0 && !evt_out));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (div_cnt < cfg_ratio || cfg_change || !$stable(cfg_ratio)));

   // R4
   ratio_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_q && cfg_valid && !cfg_change && cfg_ratio == CNT_W'(1)) |=> evt_out);

   // R8
   evt_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out |-> $past(rise_q));
endmodule

bind spot_prescaler spot_prescaler_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .freq_code(freq_code), .evt_out(evt_out),
   .rise_q(rise_q), .cfg_valid(cfg_valid), .cfg_change(cfg_change),
   .cfg_ratio(cfg_ratio), .div_cnt(div_cnt)
);

// File: tb/sim_spot_prescaler.sv
`timescale 1ns/1ps
module sim_spot_prescaler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic [3:0] freq_code = 4'd0;
   logic       div8k_mode = 1'b1;
   logic       evt_out;
   int         checks = 0;
   int         errors = 0;
   int         ev_total = 0;
   int         base = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   spot_prescaler u0 (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
      .freq_code(freq_code), .div8k_mode(div8k_mode), .evt_out(evt_out)
   );

   always @(negedge clk) if (evt_out) ev_total++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [3:0] c, input logic m);
      freq_code = 4'd15;
      @(negedge clk);
      freq_code  = c;
      div8k_mode = m;
      repeat (3) @(negedge clk);
      base = ev_total;
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) begin
         ref_in = 1'b1;
         repeat (2) @(negedge clk);
         ref_in = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 evt_out low after reset", int'(evt_out), 0);
   endtask

   task automatic t_ratio(input logic [3:0] c, input int r, input string req);
      set_cfg(c, 1'b1);
      edges(r - 1);
      check({req, " no event before ratio-th edge"}, ev_total - base, 0);
      edges(1);
      check({req, " event on ratio-th edge"}, ev_total - base, 1);
   endtask

   task automatic t_steady();
      set_cfg(4'd3, 1'b1);
      edges(193 * 2);
      check("R5 steady one event per 193 edges", ev_total - base, 2);
   endtask

   task automatic t_direct();
      set_cfg(4'd4, 1'b0);
      edges(10);
      check("R3 direct code 4 one event per edge", ev_total - base, 10);
      set_cfg(4'd11, 1'b0);
      edges(10);
      check("R3 direct code 11 halved", ev_total - base, 5);
   endtask

   task automatic t_low();
      set_cfg(4'd0, 1'b1);
      edges(5);
      check("R4 code 0 8k mode passes", ev_total - base, 5);
      set_cfg(4'd2, 1'b0);
      edges(5);
      check("R4 code 2 direct passes", ev_total - base, 5);
   endtask

   task automatic t_bad();
      set_cfg(4'd13, 1'b1);
      edges(20);
      check("R7 code 13 8k mode silent", ev_total - base, 0);
      set_cfg(4'd12, 1'b0);
      edges(20);
      check("R7 code 12 direct silent", ev_total - base, 0);
   endtask

   task automatic t_restart();
      set_cfg(4'd4, 1'b1);
      edges(100);
      freq_code = 4'd5;
      repeat (2) @(negedge clk);
      freq_code = 4'd4;
      repeat (2) @(negedge clk);
      base = ev_total;
      edges(255);
      check("R6 no early event after restart", ev_total - base, 0);
      edges(1);
      check("R6 event after full ratio", ev_total - base, 1);
   endtask

   task automatic t_level();
      set_cfg(4'd4, 1'b0);
      ref_in = 1'b1;
      repeat (20) @(negedge clk);
      ref_in = 1'b0;
      repeat (6) @(negedge clk);
      check("R8 held level counts once", ev_total - base, 1);
   endtask

   task automatic t_latency();
      set_cfg(4'd4, 1'b0);
      ref_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 no event after three edges", int'(evt_out), 0);
      @(negedge clk);
      check("R9 event after fourth edge", int'(evt_out), 1);
      @(negedge clk);
      check("R8 event one cycle wide", int'(evt_out), 0);
      ref_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_ratio(4'd3, 193, "R2 R5 code 3");
      t_ratio(4'd4, 256, "R2 code 4");
      t_ratio(4'd5, 810, "R2 code 5");
      t_ratio(4'd6, 2430, "R2 code 6");
      t_ratio(4'd10, 9720, "R2 code 10");
      t_steady();
      t_direct();
      t_low();
      t_bad();
      t_restart();
      t_level();
      t_latency();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule